// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a three-wire stereo PCM stream into parallel left and right samples. The wires are a bit clock, a frame clock that marks the left and right halves, and a data line. All three are treated as slow asynchronous inputs. A fast system clock samples them, and the block acts on each rising edge of the bit clock that it sees. Every channel half holds 32 bit slots. A two-bit format input sets where the sample sits inside the half: at its start, at its end, or one slot after its start.

The block counts slots from each change of the frame clock and captures the sample at the slot that fits the chosen format. It reports a finished stereo frame with a single-cycle strobe. The left and right outputs change together in that cycle and hold their values until the next strobe. Nothing is reported until the block has seen a frame clock change, so a half-frame that was already running when reset ended is thrown away.

Top module: `pcm_frame_rx`

## Requirements
- R1: While reset is asserted and right after it ends, `left_o` and `right_o` are zero and `frame_stb_o` is low.
- R2: Serial data is two's complement and sent MSB first. A bit is sampled on the rising edge of the bit clock, and each channel half holds 32 bit slots, numbered from 0 at the first bit clock rise after a frame clock change.
- R3: With `fmt_i` = 2'b01 (18-bit, end aligned), the sample is taken from slots 14 to 31 of the half.
- R4: With `fmt_i` = 2'b00 (16-bit, end aligned), the sample is taken from slots 16 to 31 and is output as {sample, 2'b00}.
- R5: With `fmt_i` = 2'b11 (18-bit, delayed by one slot), the sample is taken from slots 1 to 18, and a low frame clock marks the left half.
- R6: With `fmt_i` = 2'b10 (18-bit, start aligned), the sample is taken from slots 0 to 17. In formats 00, 01 and 10, a high frame clock marks the left half.
- R7: Bits in slots outside the selected window have no effect on either output.
- R8: `frame_stb_o` rises for exactly one cycle after the right sample of a frame completes. Both outputs update in that cycle and are otherwise stable.
- R9: The full-scale codes 18'h1FFFF and 18'h20000 pass through unchanged.
- R10: In format 2'b10, 16-bit data followed by two zero bits comes out as {sample, 2'b00}.
- R11: No strobe is issued before the first frame clock change after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Frame clock that selects the channel half |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing format select |
| left_o | output | 18 | Left sample |
| right_o | output | 18 | Right sample |
| frame_stb_o | output | 1 | One-cycle pulse when a new frame is on the outputs |

## Verification
In start-aligned format, the restart of the slot counter on a frame clock change and the capture of the sample's MSB happen on the same bit clock event. In delayed format, the restart happens one slot before the MSB. The bench sends frames back to back with the MSB set and unused slots filled with ones. A count that restarts late or early would show up as a shifted word. Each frame's left and right words are predicted from the slot window and compared against the outputs when the strobe arrives.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int unsigned WORD_W  = 18;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned SLOTS   = 32;
  localparam int unsigned SLOT_W  = $clog2(SLOTS);

  typedef enum logic [1:0] {
    FMT_END16   = 2'b00,
    FMT_END18   = 2'b01,
    FMT_START18 = 2'b10,
    FMT_DELAY18 = 2'b11
  } fmt_e;

  // Slot index at which the sample's last bit arrives.
  function automatic logic [SLOT_W-1:0] last_slot(input fmt_e f);
    case (f)
      FMT_START18: last_slot = SLOT_W'(WORD_W - 1);
      FMT_DELAY18: last_slot = SLOT_W'(WORD_W);
      default:     last_slot = SLOT_W'(SLOTS - 1);
    endcase
  endfunction
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int unsigned LINES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;
    always_comb pipe_d = {pipe_q[STAGES-2:0], async_i[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end
    assign sync_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  logic              fclk_s,
  input  logic              sdat_s,
  input  fmt_e              fmt,
  output logic              evt_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              left_o,
  output logic              bit_o,
  output logic              locked_o
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(SLOTS - 1);

  logic              bclk_d_q, bclk_d_d;
  logic              fclk_d_q, fclk_d_d;
  logic              seen_q, seen_d;
  logic              locked_q, locked_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              left_q, left_d;
  logic              bit_q, bit_d;
  logic              evt_q, evt_d;
  logic              rise;
  logic              fedge;

  always_comb begin
    rise     = bclk_s & ~bclk_d_q;
    fedge    = seen_q & (fclk_s != fclk_d_q);
    bclk_d_d = bclk_s;
    evt_d    = rise;
    fclk_d_d = fclk_d_q;
    seen_d   = seen_q;
    locked_d = locked_q;
    slot_d   = slot_q;
    left_d   = left_q;
    bit_d    = bit_q;
    if (rise) begin
      fclk_d_d = fclk_s;
      seen_d   = 1'b1;
      bit_d    = sdat_s;
      left_d   = (fmt == FMT_DELAY18) ? ~fclk_s : fclk_s;
      if (fedge) begin
        locked_d = 1'b1;
        slot_d   = '0;
      end else if (slot_q != SLOT_MAX) begin
        slot_d   = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d_q <= 1'b0;
      fclk_d_q <= 1'b0;
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
      slot_q   <= SLOT_MAX;
      left_q   <= 1'b0;
      bit_q    <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      bclk_d_q <= bclk_d_d;
      fclk_d_q <= fclk_d_d;
      seen_q   <= seen_d;
      locked_q <= locked_d;
      slot_q   <= slot_d;
      left_q   <= left_d;
      bit_q    <= bit_d;
      evt_q    <= evt_d;
    end
  end

  assign evt_o    = evt_q;
  assign slot_o   = slot_q;
  assign left_o   = left_q;
  assign bit_o    = bit_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
  import pcm_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [SLOT_W-1:0] slot,
  input  logic              left_half,
  input  logic              bit_in,
  input  logic              locked,
  input  fmt_e              fmt,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              stb_o
);
  localparam int unsigned PAD_W = WORD_W - SHORT_W;

  logic [WORD_W-1:0] shift_q, shift_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] left_q, left_d;
  logic [WORD_W-1:0] right_q, right_d;
  logic              stb_q, stb_d;
  logic [WORD_W-1:0] word;
  logic              take;

  always_comb begin
    shift_d = shift_q;
    hold_d  = hold_q;
    left_d  = left_q;
    right_d = right_q;
    stb_d   = 1'b0;
    take    = evt & locked;
    if (fmt == FMT_END16)
      word = {shift_q[SHORT_W-2:0], bit_in, {PAD_W{1'b0}}};
    else
      word = {shift_q[WORD_W-2:0], bit_in};
    if (take) begin
      shift_d = {shift_q[WORD_W-2:0], bit_in};
      if (slot == last_slot(fmt)) begin
        if (left_half) begin
          hold_d = word;
        end else begin
          left_d  = hold_q;
          right_d = word;
          stb_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      hold_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      stb_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      hold_q  <= hold_d;
      left_q  <= left_d;
      right_q <= right_d;
      stb_q   <= stb_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign stb_o   = stb_q;
endmodule

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx
  import pcm_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              frame_stb_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [2:0]        lines_s;
  logic              bit_evt;
  logic [SLOT_W-1:0] slot;
  logic              left_half;
  logic              bit_v;
  logic              locked;
  fmt_e              fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];
  assign fmt       = fmt_e'(fmt_i);

  pcm_rx_sync #(.LINES(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({sdata_i, fclk_i, bclk_i}),
    .sync_o  (lines_s)
  );

  pcm_rx_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bclk_s   (lines_s[0]),
    .fclk_s   (lines_s[1]),
    .sdat_s   (lines_s[2]),
    .fmt      (fmt),
    .evt_o    (bit_evt),
    .slot_o   (slot),
    .left_o   (left_half),
    .bit_o    (bit_v),
    .locked_o (locked)
  );

  pcm_rx_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt       (bit_evt),
    .slot      (slot),
    .left_half (left_half),
    .bit_in    (bit_v),
    .locked    (locked),
    .fmt       (fmt),
    .left_o    (left_o),
    .right_o   (right_o),
    .stb_o     (frame_stb_o)
  );
endmodule

// File: rtl/pcm_frame_rx_chk.sv
module pcm_frame_rx_chk
  import pcm_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        fmt_i,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              frame_stb_o,
  input logic              bit_evt,
  input logic              locked
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |=> !frame_stb_o);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb_o |-> ($stable(left_o) && $stable(right_o)));

  a_r8_after_bit_event: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |-> $past(bit_evt));

  a_r11_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |-> locked);

  a_r4_zero_lsbs: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb_o && fmt_i == 2'b00) |-> (left_o[1:0] == 2'b00 && right_o[1:0] == 2'b00));
endmodule

bind pcm_frame_rx pcm_frame_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fmt_i       (fmt_i),
  .left_o      (left_o),
  .right_o     (right_o),
  .frame_stb_o (frame_stb_o),
  .bit_evt     (bit_evt),
  .locked      (locked)
);

// File: tb/pcm_frame_rx_tb_top.sv
`timescale 1ns/1ps
module pcm_frame_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk, fclk, sdata;
  logic [1:0]  fmt;
  logic [17:0] left_o, right_o;
  logic        frame_stb_o;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;
  logic [35:0] exp_q[$];

  always #4 clk = ~clk;

  pcm_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .frame_stb_o(frame_stb_o)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit of the half-frame in slot k for a given format (R3 R4 R5 R6), pad elsewhere (R7)
  function automatic logic slot_bit(input logic [1:0] m, input logic [17:0] w,
                                    input int k, input logic pad);
    case (m)
      2'b00:   slot_bit = (k >= 16) ? w[17-(k-16)] : pad;
      2'b01:   slot_bit = (k >= 14) ? w[17-(k-14)] : pad;
      2'b10:   slot_bit = (k <= 17) ? w[17-k] : pad;
      default: slot_bit = (k >= 1 && k <= 18) ? w[18-k] : pad;
    endcase
  endfunction

  task automatic send_half(input logic fc, input logic [17:0] w, input logic pad);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      bclk = 1'b0; fclk = fc; sdata = slot_bit(fmt, w, k, pad);
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  // Driver: pushes expected frame then serialises it
  task automatic send_frame(input logic [17:0] l, input logic [17:0] r, input logic pad);
    logic lv;
    lv = (fmt == 2'b11) ? 1'b0 : 1'b1;
    if (fmt == 2'b00) exp_q.push_back({l[17:2], 2'b00, r[17:2], 2'b00});
    else              exp_q.push_back({l, r});
    send_half(lv, l, pad);
    send_half(~lv, r, pad);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && frame_stb_o) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 actual=unexpected strobe expected=no strobe");
      end else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        check("R8 frame words", {left_o, right_o}, e);
      end
    end
  end

  task automatic start_mode(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; fmt = m; bclk = 1'b0; sdata = 1'b0;
    fclk = (m == 2'b11) ? 1'b1 : 1'b0;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {left_o, right_o}, 36'h0);
    check("R1 reset strobe", {35'h0, frame_stb_o}, 36'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // preamble half in the right-channel level: must not strobe (R11)
    send_half(fclk, 18'h3FFFF, 1'b1);
  endtask

  task automatic finish_mode(input string req);
    repeat (40) @(negedge clk);
    check(req, {35'h0, exp_q.size() == 0}, 36'h1);
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0; sdata = 1'b0; fmt = 2'b10;
    // R6 R2 R9 R10: start aligned, MSB restart on same event
    start_mode(2'b10);
    send_frame(18'h1FFFF, 18'h20000, 1'b1);
    send_frame(18'h2A5A5, 18'h15A5A, 1'b0);
    send_frame({16'hBEEF, 2'b00}, {16'h8001, 2'b00}, 1'b1);
    send_frame(18'h00001, 18'h3FFFE, 1'b1);
    finish_mode("R6 all frames seen");
    // R5: delayed by one slot, left on low frame clock
    start_mode(2'b11);
    send_frame(18'h1FFFF, 18'h20000, 1'b1);
    send_frame(18'h12345, 18'h2ABCD, 1'b1);
    send_frame(18'h20001, 18'h00002, 1'b0);
    finish_mode("R5 all frames seen");
    // R3: 18-bit end aligned
    start_mode(2'b01);
    send_frame(18'h20000, 18'h1FFFF, 1'b1);
    send_frame(18'h0F0F0, 18'h30303, 1'b1);
    send_frame(18'h00000, 18'h3FFFF, 1'b0);
    finish_mode("R3 all frames seen");
    // R4: 16-bit end aligned, padded with zero LSBs
    start_mode(2'b00);
    send_frame({16'h7FFF, 2'b00}, {16'h8000, 2'b00}, 1'b1);
    send_frame({16'h1234, 2'b00}, {16'hFEDC, 2'b00}, 1'b1);
    finish_mode("R4 all frames seen");
    // R7: held outputs unchanged while padding toggles is covered by pad=1 frames above
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule